// File: doc/BRIEF.md
# Register-Mapped Serial EEPROM Byte Controller

This block gives a host single-byte access to an external two-wire serial EEPROM through five byte-wide registers. The host selects a register with a 3-bit select, writes it with a one-cycle strobe and reads any register combinationally. There are two address bytes, a data byte, a control byte and a status byte. Transfers start as side effects of register writes. With write mode enabled, a write to the data register starts a byte write. With write mode clear, a write to the low address register starts a byte read.

The bus master builds every transfer from START, STOP and single-bit slots. Each bit takes four quarter-periods, and each quarter lasts `QTR_DIV` system clocks. SDA is open-drain: `sda_oe` pulls the line low. The EEPROM answers at the fixed 7-bit device address 1010000.

A busy EEPROM does not stall the controller. It refuses the address phase, which shows up as an acknowledge error that the host resolves by retrying. The status byte reports readiness and idleness as two separate bits.

Top module: `eepc_top`

## Requirements
- R1: After reset the status register (select 4) reads 0x03, SCL is high and SDA is released (`sda_oe` = 0).
- R2: Control byte bit 7 enables the controller, bit 6 selects write mode and bit 5 selects two-byte addressing. With bits 7 and 6 set and bit 5 clear, a data register write (select 2) stores the data byte at the EEPROM address held in the low address register (select 0).
- R3: With control bit 5 set, the high address register (select 1) is sent before the low one, and write and read use the full two-byte address.
- R4: With control bit 7 set and bit 6 clear, a write to the low address register starts a read. At completion the received byte is in the data register.
- R5: Status bit 0 (done) and bit 1 (idle) both read 0 from the cycle after launch until completion, and both return to 1 together. The pattern idle without done never occurs.
- R6: If the EEPROM refuses any address-phase byte, status bit 2 is set and a STOP ends the transfer. No byte is stored. An abandoned read leaves 0xFF in the data register.
- R7: If the data byte of a write is refused, status bit 3 is set and bit 2 stays clear.
- R8: Status bits 2 and 3 keep their value until the next launch, which clears them.
- R9: A launching write while control bit 7 is clear starts nothing. Status stays 0x03 and SCL stays high.
- R10: Register writes while a transfer is in progress are ignored. They neither change registers nor start a second transfer.
- R11: A write uses exactly one START and one STOP. A read uses two STARTs (the second one a repeated START) and one STOP.
- R12: The control register reads back only bits 7, 6 and 5; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select: 0 addr low, 1 addr high, 2 data, 3 control, 4 status |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Selected register contents |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with `QTR_DIV` = 2, so one bus bit costs about ten system clocks. This puts several dozen complete write and read-back transfers within the run time. The bench attaches a behavioural EEPROM to the bus. That model can refuse its device address a chosen number of times and can refuse a data byte. These two controls reach both error paths, the retry after a busy refusal, and the 0xFF left behind by an abandoned read.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_BIT   = 2'd2
  } bitcmd_e;

  typedef enum logic [3:0] {
    SQ_IDLE   = 4'd0,
    SQ_START  = 4'd1,
    SQ_DEVW   = 4'd2,
    SQ_AHI    = 4'd3,
    SQ_ALO    = 4'd4,
    SQ_WDATA  = 4'd5,
    SQ_RSTART = 4'd6,
    SQ_DEVR   = 4'd7,
    SQ_RDATA  = 4'd8,
    SQ_STOP   = 4'd9,
    SQ_FINISH = 4'd10
  } seq_e;

  localparam logic [2:0] SEL_ALO  = 3'd0;
  localparam logic [2:0] SEL_AHI  = 3'd1;
  localparam logic [2:0] SEL_DATA = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  localparam int CB_EN  = 7;
  localparam int CB_WR  = 6;
  localparam int CB_A16 = 5;
endpackage

// File: rtl/eepc_qtick.sv
module eepc_qtick #(
  parameter int QTR_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eepc_bitphy.sv
module eepc_bitphy
  import eepc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_go,
  input  bitcmd_e cmd,
  input  logic    cmd_bit,
  input  logic    tick,
  input  logic    sda_i,
  output logic    active,
  output logic    done,
  output logic    rbit,
  output logic    scl_o,
  output logic    sda_oe
);
  logic    act_q, act_d;
  logic [1:0] qtr_q, qtr_d;
  bitcmd_e cmd_q, cmd_d;
  logic    bit_q, bit_d;
  logic    scl_q, scl_d;
  logic    oe_q, oe_d;
  logic    rbit_q, rbit_d;
  logic    done_q, done_d;
  logic [1:0] nqtr;

  assign nqtr = qtr_q + 2'd1;

  always_comb begin
    act_d  = act_q;
    qtr_d  = qtr_q;
    cmd_d  = cmd_q;
    bit_d  = bit_q;
    scl_d  = scl_q;
    oe_d   = oe_q;
    rbit_d = rbit_q;
    done_d = 1'b0;
    if (cmd_go && !act_q) begin
      act_d = 1'b1;
      qtr_d = 2'd0;
      cmd_d = cmd;
      bit_d = cmd_bit;
      scl_d = 1'b0;
    end else if (act_q && tick) begin
      if (qtr_q == 2'd3) begin
        act_d  = 1'b0;
        done_d = 1'b1;
        rbit_d = sda_i;
      end else begin
        qtr_d = nqtr;
        case (nqtr)
          2'd1: begin
            scl_d = 1'b0;
            case (cmd_q)
              BC_START: oe_d = 1'b0;
              BC_STOP:  oe_d = 1'b1;
              default:  oe_d = !bit_q;
            endcase
          end
          2'd2: scl_d = 1'b1;
          default: begin
            scl_d = 1'b1;
            if (cmd_q == BC_START) oe_d = 1'b1;
            if (cmd_q == BC_STOP)  oe_d = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      qtr_q  <= 2'd0;
      cmd_q  <= BC_BIT;
      bit_q  <= 1'b1;
      scl_q  <= 1'b1;
      oe_q   <= 1'b0;
      rbit_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      qtr_q  <= qtr_d;
      cmd_q  <= cmd_d;
      bit_q  <= bit_d;
      scl_q  <= scl_d;
      oe_q   <= oe_d;
      rbit_q <= rbit_d;
      done_q <= done_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;
  assign rbit   = rbit_q;
  assign scl_o  = scl_q;
  assign sda_oe = oe_q;
endmodule

// File: rtl/eepc_xfer.sv
module eepc_xfer
  import eepc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       is_write,
  input  logic       two_byte,
  input  logic [7:0] addr_hi,
  input  logic [7:0] addr_lo,
  input  logic [7:0] wdata,
  input  logic       phy_done,
  input  logic       phy_rbit,
  output logic       phy_go,
  output bitcmd_e    phy_cmd,
  output logic       phy_bit,
  output logic       busy,
  output logic       finish,
  output logic       ack_err,
  output logic       gen_err,
  output logic [7:0] rx_byte
);
  localparam logic [7:0] DEV_W = {DEV_ADDR, 1'b0};
  localparam logic [7:0] DEV_R = {DEV_ADDR, 1'b1};

  seq_e       st_q, st_d;
  logic       wait_q, wait_d;
  logic [3:0] bcnt_q, bcnt_d;
  logic [7:0] rx_q, rx_d;
  logic       aerr_q, aerr_d;
  logic       gerr_q, gerr_d;
  logic [7:0] tx;
  logic       acked;

  always_comb begin
    case (st_q)
      SQ_DEVW:  tx = DEV_W;
      SQ_AHI:   tx = addr_hi;
      SQ_ALO:   tx = addr_lo;
      SQ_WDATA: tx = wdata;
      SQ_DEVR:  tx = DEV_R;
      default:  tx = 8'hFF;
    endcase
  end

  assign phy_go  = (st_q != SQ_IDLE) && (st_q != SQ_FINISH) && !wait_q;
  assign phy_cmd = (st_q == SQ_START || st_q == SQ_RSTART) ? BC_START :
                   (st_q == SQ_STOP) ? BC_STOP : BC_BIT;
  assign phy_bit = bcnt_q[3] ? 1'b1 : tx[~bcnt_q[2:0]];
  assign acked   = !phy_rbit;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    bcnt_d = bcnt_q;
    rx_d   = rx_q;
    aerr_d = aerr_q;
    gerr_d = gerr_q;
    if (st_q == SQ_IDLE) begin
      if (launch) begin
        st_d   = SQ_START;
        rx_d   = 8'hFF;
        aerr_d = 1'b0;
        gerr_d = 1'b0;
        bcnt_d = 4'd0;
      end
    end else if (st_q == SQ_FINISH) begin
      st_d = SQ_IDLE;
    end else if (phy_go) begin
      wait_d = 1'b1;
    end else if (phy_done) begin
      wait_d = 1'b0;
      case (st_q)
        SQ_START:  st_d = SQ_DEVW;
        SQ_RSTART: st_d = SQ_DEVR;
        SQ_STOP:   st_d = SQ_FINISH;
        default: begin
          if (!bcnt_q[3]) begin
            bcnt_d = bcnt_q + 4'd1;
            if (st_q == SQ_RDATA) rx_d = {rx_q[6:0], phy_rbit};
          end else begin
            bcnt_d = 4'd0;
            case (st_q)
              SQ_DEVW: begin
                if (acked) st_d = two_byte ? SQ_AHI : SQ_ALO;
                else begin aerr_d = 1'b1; st_d = SQ_STOP; end
              end
              SQ_AHI: begin
                if (acked) st_d = SQ_ALO;
                else begin aerr_d = 1'b1; st_d = SQ_STOP; end
              end
              SQ_ALO: begin
                if (acked) st_d = is_write ? SQ_WDATA : SQ_RSTART;
                else begin aerr_d = 1'b1; st_d = SQ_STOP; end
              end
              SQ_WDATA: begin
                if (!acked) gerr_d = 1'b1;
                st_d = SQ_STOP;
              end
              SQ_DEVR: begin
                if (acked) st_d = SQ_RDATA;
                else begin aerr_d = 1'b1; st_d = SQ_STOP; end
              end
              default: st_d = SQ_STOP;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      wait_q <= 1'b0;
      bcnt_q <= 4'd0;
      rx_q   <= 8'hFF;
      aerr_q <= 1'b0;
      gerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      bcnt_q <= bcnt_d;
      rx_q   <= rx_d;
      aerr_q <= aerr_d;
      gerr_q <= gerr_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign finish  = (st_q == SQ_FINISH);
  assign ack_err = aerr_q;
  assign gen_err = gerr_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/eepc_top.sv
module eepc_top
  import eepc_pkg::*;
#(
  parameter int         QTR_DIV  = 125,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [2:0] host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       scl_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic [7:0] alo_q, alo_d, ahi_q, ahi_d, dat_q, dat_d;
  logic       cen_q, cen_d, cwr_q, cwr_d, ca16_q, ca16_d;
  logic       sdone_q, sdone_d, sidle_q, sidle_d;
  logic       aerr_q, aerr_d, gerr_q, gerr_d;
  logic       launch_q, launch_d;
  logic       ready, wr_ok;

  logic       xfer_busy, xfer_fin, xfer_aerr, xfer_gerr;
  logic [7:0] xfer_rx;
  logic       phy_go, phy_bit, phy_done, phy_rbit, phy_act, qtick;
  bitcmd_e    phy_cmd;

  assign ready = sdone_q & sidle_q;
  assign wr_ok = host_wr & ready;

  always_comb begin
    launch_d = 1'b0;
    if (wr_ok && cen_q) begin
      if (host_sel == SEL_DATA && cwr_q)  launch_d = 1'b1;
      if (host_sel == SEL_ALO  && !cwr_q) launch_d = 1'b1;
    end
  end

  always_comb begin
    alo_d   = alo_q;
    ahi_d   = ahi_q;
    dat_d   = dat_q;
    cen_d   = cen_q;
    cwr_d   = cwr_q;
    ca16_d  = ca16_q;
    sdone_d = sdone_q;
    sidle_d = sidle_q;
    aerr_d  = aerr_q;
    gerr_d  = gerr_q;
    if (wr_ok) begin
      case (host_sel)
        SEL_ALO:  alo_d = host_wdata;
        SEL_AHI:  ahi_d = host_wdata;
        SEL_DATA: dat_d = host_wdata;
        SEL_CTRL: begin
          cen_d  = host_wdata[CB_EN];
          cwr_d  = host_wdata[CB_WR];
          ca16_d = host_wdata[CB_A16];
        end
        default: ;
      endcase
    end
    if (launch_d) begin
      sdone_d = 1'b0;
      sidle_d = 1'b0;
      aerr_d  = 1'b0;
      gerr_d  = 1'b0;
    end
    if (xfer_fin) begin
      sdone_d = 1'b1;
      sidle_d = 1'b1;
      aerr_d  = xfer_aerr;
      gerr_d  = xfer_gerr;
      if (!cwr_q) dat_d = xfer_rx;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      alo_q    <= 8'h00;
      ahi_q    <= 8'h00;
      dat_q    <= 8'h00;
      cen_q    <= 1'b0;
      cwr_q    <= 1'b0;
      ca16_q   <= 1'b0;
      sdone_q  <= 1'b1;
      sidle_q  <= 1'b1;
      aerr_q   <= 1'b0;
      gerr_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      alo_q    <= alo_d;
      ahi_q    <= ahi_d;
      dat_q    <= dat_d;
      cen_q    <= cen_d;
      cwr_q    <= cwr_d;
      ca16_q   <= ca16_d;
      sdone_q  <= sdone_d;
      sidle_q  <= sidle_d;
      aerr_q   <= aerr_d;
      gerr_q   <= gerr_d;
      launch_q <= launch_d;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_ALO:  host_rdata = alo_q;
      SEL_AHI:  host_rdata = ahi_q;
      SEL_DATA: host_rdata = dat_q;
      SEL_CTRL: host_rdata = {cen_q, cwr_q, ca16_q, 5'b0};
      SEL_STAT: host_rdata = {4'b0, gerr_q, aerr_q, sidle_q, sdone_q};
      default:  host_rdata = 8'h00;
    endcase
  end

  eepc_xfer #(.DEV_ADDR(DEV_ADDR)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .launch   (launch_q),
    .is_write (cwr_q),
    .two_byte (ca16_q),
    .addr_hi  (ahi_q),
    .addr_lo  (alo_q),
    .wdata    (dat_q),
    .phy_done (phy_done),
    .phy_rbit (phy_rbit),
    .phy_go   (phy_go),
    .phy_cmd  (phy_cmd),
    .phy_bit  (phy_bit),
    .busy     (xfer_busy),
    .finish   (xfer_fin),
    .ack_err  (xfer_aerr),
    .gen_err  (xfer_gerr),
    .rx_byte  (xfer_rx)
  );

  eepc_qtick #(.QTR_DIV(QTR_DIV)) u_qtick (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (phy_go),
    .run   (phy_act),
    .tick  (qtick)
  );

  eepc_bitphy u_phy (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cmd_go  (phy_go),
    .cmd     (phy_cmd),
    .cmd_bit (phy_bit),
    .tick    (qtick),
    .sda_i   (sda_i),
    .active  (phy_act),
    .done    (phy_done),
    .rbit    (phy_rbit),
    .scl_o   (scl_o),
    .sda_oe  (sda_oe)
  );
endmodule

// File: rtl/eepc_chk.sv
module eepc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       launch,
  input logic       seq_busy,
  input logic       st_done,
  input logic       st_idle,
  input logic       ack_err,
  input logic       gen_err,
  input logic [7:0] addr_lo,
  input logic       scl_o
);
  // R5
  idle_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> st_done);

  // R5
  launch_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!st_idle && !st_done));

  // R8
  ackerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_err) |-> launch);

  // R8
  generr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_err) |-> launch);

  // R10
  busy_locks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && host_wr) |=> $stable(addr_lo));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> scl_o);
endmodule

bind eepc_top eepc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_wr  (host_wr),
  .launch   (launch_q),
  .seq_busy (xfer_busy),
  .st_done  (sdone_q),
  .st_idle  (sidle_q),
  .ack_err  (aerr_q),
  .gen_err  (gerr_q),
  .addr_lo  (alo_q),
  .scl_o    (scl_o)
);

// File: tb/sim_eepc_top.sv
module sim_eepc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_sel = 3'd4;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       scl_o, sda_oe;
  logic       slv_low = 1'b0;
  wire        sda_line = !(sda_oe | slv_low);

  always #4 clk = !clk;

  eepc_top #(.QTR_DIV(2), .DEV_ADDR(7'h50)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  // ---------------- behavioural EEPROM on the bus ----------------
  localparam int PH_IDLE = 0, PH_DEV = 1, PH_AHI = 2, PH_ALO = 3, PH_DATA = 4, PH_RD = 5;
  int         ph = PH_IDLE;
  int         bc = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] outb = 8'h00;
  logic [9:0] ptr = 10'd0;
  logic       ack_now = 1'b0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] mem [0:1023];
  int         starts = 0, stops = 0, nack_used = 0;
  int         nack_budget = 0;
  bit         model_a16 = 1'b0;
  bit         nack_data = 1'b0;

  always @(scl_o, sda_line) begin
    if (rst_n === 1'b1) begin
      if (scl_o && prev_scl && prev_sda && !sda_line) begin
        starts++; ph = PH_DEV; bc = 0; slv_low = 1'b0;
      end else if (scl_o && prev_scl && !prev_sda && sda_line) begin
        stops++; ph = PH_IDLE; slv_low = 1'b0;
      end else if (scl_o && !prev_scl) begin
        if (ph == PH_RD) begin
          if (bc < 8) bc++;
          else ph = PH_IDLE;
        end else if (ph != PH_IDLE) begin
          if (bc < 8) begin
            sh = {sh[6:0], sda_line};
            bc++;
            if (bc == 8) begin
              if (ph == PH_DEV) begin
                if (sh[7:1] != 7'h50) ack_now = 1'b0;
                else if (nack_used < nack_budget) begin ack_now = 1'b0; nack_used++; end
                else ack_now = 1'b1;
              end else if (ph == PH_DATA) ack_now = !nack_data;
              else ack_now = 1'b1;
            end
          end else begin
            bc = 0;
            if (!ack_now) ph = PH_IDLE;
            else begin
              case (ph)
                PH_DEV: begin
                  if (sh[0]) begin ph = PH_RD; outb = mem[ptr]; end
                  else ph = model_a16 ? PH_AHI : PH_ALO;
                end
                PH_AHI: begin ptr[9:8] = sh[1:0]; ph = PH_ALO; end
                PH_ALO: begin
                  if (model_a16) ptr[7:0] = sh; else ptr = {2'b00, sh};
                  ph = PH_DATA;
                end
                PH_DATA: begin mem[ptr] = sh; ph = PH_IDLE; end
                default: ph = PH_IDLE;
              endcase
            end
          end
        end
      end else if (!scl_o && prev_scl) begin
        if (ph == PH_RD) slv_low = (bc < 8) ? !outb[7 - bc] : 1'b0;
        else if (ph != PH_IDLE) slv_low = (bc == 8) && ack_now;
        else slv_low = 1'b0;
      end
    end
    prev_scl = scl_o;
    prev_sda = sda_line;
  end

  // ---------------- bench functions and tasks ----------------
  logic [7:0] shadow [0:1023];

  function automatic logic [7:0] exp_status(input logic ae, input logic ge);
    return {4'b0, ge, ae, 2'b11};
  endfunction

  function automatic logic [7:0] ctrl_val(input logic en, input logic wr, input logic a16);
    return {en, wr, a16, 5'b0};
  endfunction

  function automatic logic [9:0] map_addr(input logic a16, input logic [7:0] hi, input logic [7:0] lo);
    return a16 ? {hi[1:0], lo} : {2'b00, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hw(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk);
    host_sel = sel; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] sel, output logic [7:0] v);
    host_sel = sel;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] s;
    int n = 0;
    hr(3'd4, s);
    while (s[1:0] != 2'b11 && n < 20000) begin
      @(negedge clk); n++;
      hr(3'd4, s);
    end
    if (n >= 20000) chk({tag, " timeout"}, 32'd0, 32'd1);
  endtask

  task automatic do_write(input logic a16, input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
    model_a16 = a16;
    hw(3'd3, ctrl_val(1'b1, 1'b1, a16));
    hw(3'd1, hi);
    hw(3'd0, lo);
    hw(3'd2, d);
    wait_ready("write");
  endtask

  task automatic do_read(input logic a16, input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] d);
    model_a16 = a16;
    hw(3'd3, ctrl_val(1'b1, 1'b0, a16));
    hw(3'd1, hi);
    hw(3'd0, lo);
    wait_ready("read");
    hr(3'd2, d);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0, p0;
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    hr(3'd4, v); chk("R1 status", v, 8'h03);
    chk("R1 scl", scl_o, 1'b1);
    chk("R1 sda_oe", sda_oe, 1'b0);

    // R2 one-byte write, R5 busy pattern, R11 bus framing
    model_a16 = 1'b0;
    hw(3'd3, ctrl_val(1'b1, 1'b1, 1'b0));
    hw(3'd0, 8'h12);
    s0 = starts; p0 = stops;
    hw(3'd2, 8'h5A);
    hr(3'd4, v); chk("R5 busy status", v, 8'h00);
    wait_ready("R2");
    hr(3'd4, v); chk("R5 done status", v, exp_status(1'b0, 1'b0));
    chk("R2 stored", mem[10'h012], 8'h5A);
    shadow[10'h012] = 8'h5A;
    chk("R11 write starts", starts - s0, 1);
    chk("R11 write stops", stops - p0, 1);

    // R4 read back, R11 repeated start
    s0 = starts; p0 = stops;
    do_read(1'b0, 8'h00, 8'h12, v);
    chk("R4 read data", v, shadow[10'h012]);
    chk("R11 read starts", starts - s0, 2);
    chk("R11 read stops", stops - p0, 1);

    // R3 two-byte addressing
    do_write(1'b1, 8'h03, 8'h45, 8'hC3);
    chk("R3 stored 0x345", mem[10'h345], 8'hC3);
    shadow[10'h345] = 8'hC3;
    do_read(1'b1, 8'h03, 8'h45, v);
    chk("R3 read 0x345", v, 8'hC3);

    // R6 busy EEPROM refuses address on write, R8 sticky, then retry
    do_write(1'b0, 8'h00, 8'h20, 8'h11);
    shadow[10'h020] = 8'h11;
    nack_budget++;
    hw(3'd2, 8'h99);
    wait_ready("R6 w");
    hr(3'd4, v); chk("R6 ack error status", v, exp_status(1'b1, 1'b0));
    chk("R6 not stored", mem[10'h020], 8'h11);
    hw(3'd3, ctrl_val(1'b0, 1'b1, 1'b0));
    hr(3'd4, v); chk("R8 error kept", v, exp_status(1'b1, 1'b0));
    hw(3'd3, ctrl_val(1'b1, 1'b1, 1'b0));
    hw(3'd2, 8'h99);
    hr(3'd4, v); chk("R8 cleared at launch", v, 8'h00);
    wait_ready("R8 retry");
    hr(3'd4, v); chk("R8 retry ok", v, exp_status(1'b0, 1'b0));
    chk("R6 retry stored", mem[10'h020], 8'h99);
    shadow[10'h020] = 8'h99;

    // R6 abandoned read
    nack_budget++;
    do_read(1'b0, 8'h00, 8'h20, v);
    chk("R6 read data ff", v, 8'hFF);
    hr(3'd4, v); chk("R6 read status", v, exp_status(1'b1, 1'b0));

    // R7 data refused
    nack_data = 1'b1;
    do_write(1'b0, 8'h00, 8'h30, 8'h77);
    nack_data = 1'b0;
    hr(3'd4, v); chk("R7 general error", v, exp_status(1'b0, 1'b1));

    // R9 disabled controller
    do_write(1'b0, 8'h00, 8'h40, 8'h44);
    shadow[10'h040] = 8'h44;
    s0 = starts;
    hw(3'd3, ctrl_val(1'b0, 1'b1, 1'b0));
    hw(3'd2, 8'hEE);
    begin
      int lows = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!scl_o) lows++;
      end
      chk("R9 scl quiet", lows, 0);
    end
    hr(3'd4, v); chk("R9 status", v, 8'h03);
    chk("R9 no start", starts - s0, 0);
    chk("R9 mem kept", mem[10'h040], 8'h44);

    // R10 writes during busy ignored
    hw(3'd3, ctrl_val(1'b1, 1'b1, 1'b0));
    hw(3'd0, 8'h50);
    s0 = starts;
    hw(3'd2, 8'h3C);
    hw(3'd2, 8'hC5);
    hw(3'd0, 8'h51);
    wait_ready("R10");
    chk("R10 stored first", mem[10'h050], 8'h3C);
    shadow[10'h050] = 8'h3C;
    hr(3'd2, v); chk("R10 data reg", v, 8'h3C);
    hr(3'd0, v); chk("R10 addr reg", v, 8'h50);
    chk("R10 one transfer", starts - s0, 1);

    // R12 control readback
    hw(3'd3, 8'hFF);
    hr(3'd3, v); chk("R12 ctrl readback", v, 8'hE0);
    hw(3'd3, 8'h1F);
    hr(3'd3, v); chk("R12 ctrl low bits", v, 8'h00);

    // random write / read-back traffic (R2 R3 R4)
    for (int k = 0; k < 40; k++) begin
      logic       a16;
      logic [7:0] hi, lo, d, got;
      logic [9:0] ea;
      a16 = 1'($urandom);
      hi  = 8'($urandom);
      lo  = 8'($urandom);
      d   = 8'($urandom);
      ea  = map_addr(a16, hi, lo);
      do_write(a16, hi, lo, d);
      shadow[ea] = d;
      hr(3'd4, got); chk("R2 rand write status", got, exp_status(1'b0, 1'b0));
      do_read(a16, hi, lo, got);
      chk(a16 ? "R3 rand readback" : "R4 rand readback", got, shadow[ea]);
    end

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule